// File: doc/BRIEF.md
# Machine-Mode Trap Control Register Unit

This block keeps the machine-level registers a processor core needs to take and leave traps. It holds a handler vector with its mode field, a saved exception PC, a cause register, a general scratch word and a status word that carries only a saved-privilege field. It also tracks the current privilege level of the hart.

The core uses the block in three ways. It issues CSR instructions on the access port, which gives combinational read data and an illegal-address flag. It pulses the trap strobe with the cause, the interrupt flag and the PC of the faulting or interrupted instruction. It then takes the handler address from `trap_target_o`. On a machine return it pulses the return strobe, redirects fetch to `ret_pc_o` and drops to the privilege level now shown on `priv_o`.

The handler address is computed from the vector register in every cycle. In vectored mode, interrupts are sent to a per-code slot. Synchronous exceptions always go to the base address.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset `priv_o` is 2'b11 (machine). Every implemented register reads zero, and `ret_pc_o` is zero.
- R2: Register addresses are status 0x300, vector 0x305, scratch 0x340, exception PC 0x341 and cause 0x342. Operation code 2'b01 (swap) returns the old value on `csr_rdata_o` in the access cycle. The register holds the write data from the next cycle on.
- R3: Operation 2'b10 ORs the write data into the register, and 2'b11 clears the bits that are set in the write data. Both return the old value. With `csr_src_zero_i` high they write nothing. Operation 2'b00 only reads.
- R4: The scratch register stores and returns all 32 bits unchanged.
- R5: Bits [1:0] of the exception PC always read as zero, whether it was written by software or captured by a trap.
- R6: A trap strobe stores the PC and the cause. The cause reads with bit 31 set to the interrupt flag, the code in bits [3:0] and zero elsewhere. The same strobe copies the current privilege into status bits [12:11] and sets the privilege to 2'b11. A software write to the cause register keeps only bit 31 and bits [3:0].
- R7: Vector bits [1:0] select the mode, and any value other than 1 means direct. In direct mode `trap_target_o` is the vector with bits [1:0] cleared.
- R8: In vectored mode (mode 1), an interrupt targets base + 4 × code. A synchronous exception still targets the base.
- R9: `ret_pc_o` always shows the saved exception PC. On a return strobe the privilege becomes status bits [12:11], and that field is left unchanged.
- R10: When a trap strobe and a software write to the exception PC, cause or status register fall in the same cycle, the trap-captured values win.
- R11: An access to any other address raises `csr_illegal_o` in that cycle, reads zero and changes no register. The flag is low whenever `csr_valid_i` is low.
- R12: Status reads zero outside bits [12:11], and software writes change only that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Trap-taken strobe |
| trap_irq_i | input | 1 | Trap is an interrupt |
| trap_cause_i | input | 4 | Exception or interrupt code |
| trap_pc_i | input | 32 | PC of the faulting or interrupted instruction |
| mret_i | input | 1 | Machine-return strobe |
| csr_valid_i | input | 1 | CSR access this cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 00 read, 01 swap, 10 set bits, 11 clear bits |
| csr_wdata_i | input | 32 | Write operand |
| csr_src_zero_i | input | 1 | Source register is x0 |
| csr_rdata_o | output | 32 | Old register value |
| csr_illegal_o | output | 1 | Unimplemented address accessed |
| trap_target_o | output | 32 | Handler address for the presented cause |
| ret_pc_o | output | 32 | Return PC (saved exception PC) |
| priv_o | output | 2 | Current privilege level |

## Verification
Assertions check the following on every cycle:
- the privilege raise and the privilege save on a trap;
- the PC capture on a trap;
- the privilege restore on return;
- the alignment of the return PC;
- the base-address target for exceptions and for non-vectored modes;
- that the illegal flag is qualified by a valid access.

The bench covers the rest. It sweeps every mode, code and interrupt flag against arithmetically computed targets. It also shows the read-old/write-new ordering of the three operations, the suppressed write for a zero source, the field masking, the precedence of a trap over a software write in the same cycle, and that illegal accesses leave state untouched.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  typedef enum logic [1:0] {
    CSR_NOP = 2'b00,
    CSR_RW  = 2'b01,
    CSR_RS  = 2'b10,
    CSR_RC  = 2'b11
  } csr_op_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_TVEC,
    SEL_SCRATCH,
    SEL_EPC,
    SEL_CAUSE
  } csr_sel_e;

  localparam logic [11:0] ADDR_STATUS  = 12'h300;
  localparam logic [11:0] ADDR_TVEC    = 12'h305;
  localparam logic [11:0] ADDR_SCRATCH = 12'h340;
  localparam logic [11:0] ADDR_EPC     = 12'h341;
  localparam logic [11:0] ADDR_CAUSE   = 12'h342;

  localparam logic [1:0] PRIV_M    = 2'b11;
  localparam logic [1:0] MODE_VEC  = 2'b01;
  localparam int         PP_LSB    = 11;
endpackage

// File: rtl/mtrap_csr_decode.sv
module mtrap_csr_decode
  import mtrap_pkg::*;
(
  input  logic        valid_i,
  input  logic [11:0] addr_i,
  output csr_sel_e    sel_o,
  output logic        illegal_o
);
  always_comb begin
    unique case (addr_i)
      ADDR_STATUS:  sel_o = SEL_STATUS;
      ADDR_TVEC:    sel_o = SEL_TVEC;
      ADDR_SCRATCH: sel_o = SEL_SCRATCH;
      ADDR_EPC:     sel_o = SEL_EPC;
      ADDR_CAUSE:   sel_o = SEL_CAUSE;
      default:      sel_o = SEL_NONE;
    endcase
    illegal_o = valid_i && (sel_o == SEL_NONE);
  end
endmodule

// File: rtl/mtrap_csr_alu.sv
module mtrap_csr_alu
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e         op_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            src_zero_i,
  output logic [XLEN-1:0] new_o,
  output logic            we_o
);
  always_comb begin
    new_o = old_i;
    we_o  = 1'b0;
    unique case (op_i)
      CSR_RW: begin
        new_o = wdata_i;
        we_o  = 1'b1;
      end
      CSR_RS: begin
        new_o = old_i | wdata_i;
        we_o  = !src_zero_i;
      end
      CSR_RC: begin
        new_o = old_i & ~wdata_i;
        we_o  = !src_zero_i;
      end
      default: begin
        new_o = old_i;
        we_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mtrap_vector.sv
module mtrap_vector
  import mtrap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic [XLEN-1:0]   tvec_i,
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [XLEN-1:0]   target_o
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign base   = {tvec_i[XLEN-1:2], 2'b00};
  assign offset = XLEN'(code_i) << 2;

  // only interrupts are spread over slots
  assign target_o = (tvec_i[1:0] == MODE_VEC && irq_i) ? base + offset : base;
endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
  import mtrap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_i,
  input  logic              trap_irq_i,
  input  logic [CODE_W-1:0] trap_cause_i,
  input  logic [XLEN-1:0]   trap_pc_i,
  input  logic              mret_i,
  input  logic              csr_valid_i,
  input  logic [11:0]       csr_addr_i,
  input  logic [1:0]        csr_op_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic              csr_src_zero_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_illegal_o,
  output logic [XLEN-1:0]   trap_target_o,
  output logic [XLEN-1:0]   ret_pc_o,
  output logic [1:0]        priv_o
);
  logic [XLEN-1:0]   tvec_q;
  logic [XLEN-1:0]   scratch_q;
  logic [XLEN-3:0]   epc_q;
  logic              cause_irq_q;
  logic [CODE_W-1:0] cause_code_q;
  logic [1:0]        pp_q;
  logic [1:0]        priv_q;

  csr_sel_e        sel;
  logic            illegal;
  logic [XLEN-1:0] status_rd;
  logic [XLEN-1:0] cause_rd;
  logic [XLEN-1:0] old_val;
  logic [XLEN-1:0] new_val;
  logic            alu_we;
  logic            sw_we;

  mtrap_csr_decode u_dec (
    .valid_i  (csr_valid_i),
    .addr_i   (csr_addr_i),
    .sel_o    (sel),
    .illegal_o(illegal)
  );

  always_comb begin
    status_rd = '0;
    status_rd[PP_LSB +: 2] = pp_q;
    cause_rd = '0;
    cause_rd[XLEN-1] = cause_irq_q;
    cause_rd[CODE_W-1:0] = cause_code_q;
    unique case (sel)
      SEL_STATUS:  old_val = status_rd;
      SEL_TVEC:    old_val = tvec_q;
      SEL_SCRATCH: old_val = scratch_q;
      SEL_EPC:     old_val = {epc_q, 2'b00};
      SEL_CAUSE:   old_val = cause_rd;
      default:     old_val = '0;
    endcase
  end

  mtrap_csr_alu #(.XLEN(XLEN)) u_alu (
    .op_i      (csr_op_e'(csr_op_i)),
    .old_i     (old_val),
    .wdata_i   (csr_wdata_i),
    .src_zero_i(csr_src_zero_i),
    .new_o     (new_val),
    .we_o      (alu_we)
  );

  assign sw_we = csr_valid_i && alu_we && !illegal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tvec_q    <= '0;
      scratch_q <= '0;
    end else if (sw_we) begin
      if (sel == SEL_TVEC)    tvec_q    <= new_val;
      if (sel == SEL_SCRATCH) scratch_q <= new_val;
    end
  end

  // trap capture dominates software writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q        <= '0;
      cause_irq_q  <= 1'b0;
      cause_code_q <= '0;
      pp_q         <= 2'b00;
    end else if (trap_i) begin
      epc_q        <= trap_pc_i[XLEN-1:2];
      cause_irq_q  <= trap_irq_i;
      cause_code_q <= trap_cause_i;
      pp_q         <= priv_q;
    end else if (sw_we) begin
      if (sel == SEL_EPC) epc_q <= new_val[XLEN-1:2];
      if (sel == SEL_CAUSE) begin
        cause_irq_q  <= new_val[XLEN-1];
        cause_code_q <= new_val[CODE_W-1:0];
      end
      if (sel == SEL_STATUS) pp_q <= new_val[PP_LSB +: 2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     priv_q <= PRIV_M;
    else if (trap_i) priv_q <= PRIV_M;
    else if (mret_i) priv_q <= pp_q;
  end

  mtrap_vector #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
    .tvec_i  (tvec_q),
    .irq_i   (trap_irq_i),
    .code_i  (trap_cause_i),
    .target_o(trap_target_o)
  );

  assign csr_rdata_o   = old_val;
  assign csr_illegal_o = illegal;
  assign ret_pc_o      = {epc_q, 2'b00};
  assign priv_o        = priv_q;
endmodule

// File: rtl/mtrap_csr_chk.sv
module mtrap_csr_chk #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_i,
  input logic            trap_irq_i,
  input logic [XLEN-1:0] trap_pc_i,
  input logic            mret_i,
  input logic            csr_valid_i,
  input logic            csr_illegal_o,
  input logic [XLEN-1:0] trap_target_o,
  input logic [XLEN-1:0] ret_pc_o,
  input logic [1:0]      priv_o,
  input logic [1:0]      pp_q,
  input logic [XLEN-1:0] tvec_q
);
  a_r6_trap_raises_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> priv_o == 2'b11);

  a_r6_trap_saves_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> pp_q == $past(priv_o));

  a_r6_trap_pc_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> ret_pc_o[XLEN-1:2] == $past(trap_pc_i[XLEN-1:2]));

  a_r5_ret_pc_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_pc_o[1:0] == 2'b00);

  a_r9_return_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !trap_i) |=> priv_o == $past(pp_q));

  a_r8_exception_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_irq_i |-> trap_target_o == {tvec_q[XLEN-1:2], 2'b00});

  a_r7_direct_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvec_q[1:0] != 2'b01) |-> trap_target_o == {tvec_q[XLEN-1:2], 2'b00});

  a_r11_illegal_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_valid_i |-> !csr_illegal_o);
endmodule

bind mtrap_csr_unit mtrap_csr_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .trap_i       (trap_i),
  .trap_irq_i   (trap_irq_i),
  .trap_pc_i    (trap_pc_i),
  .mret_i       (mret_i),
  .csr_valid_i  (csr_valid_i),
  .csr_illegal_o(csr_illegal_o),
  .trap_target_o(trap_target_o),
  .ret_pc_o     (ret_pc_o),
  .priv_o       (priv_o),
  .pp_q         (pp_q),
  .tvec_q       (tvec_q)
);

// File: tb/sim_mtrap_csr_unit.sv
module sim_mtrap_csr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap = 1'b0;
  logic        trap_irq = 1'b0;
  logic [3:0]  trap_cause = '0;
  logic [31:0] trap_pc = '0;
  logic        mret = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  op = '0;
  logic [31:0] wdata = '0;
  logic        srcz = 1'b0;
  logic [31:0] rdata;
  logic        illegal;
  logic [31:0] target;
  logic [31:0] ret_pc;
  logic [1:0]  priv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mtrap_csr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .trap_i(trap), .trap_irq_i(trap_irq), .trap_cause_i(trap_cause), .trap_pc_i(trap_pc),
    .mret_i(mret),
    .csr_valid_i(valid), .csr_addr_i(addr), .csr_op_i(op), .csr_wdata_i(wdata),
    .csr_src_zero_i(srcz),
    .csr_rdata_o(rdata), .csr_illegal_o(illegal),
    .trap_target_o(target), .ret_pc_o(ret_pc), .priv_o(priv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one access cycle; old value and flag sampled before the edge
  task automatic acc(input logic [11:0] a, input logic [1:0] o, input logic [31:0] d,
                     input logic z, output logic [31:0] old, output logic ill);
    @(negedge clk);
    valid = 1'b1; addr = a; op = o; wdata = d; srcz = z;
    #1;
    old = rdata; ill = illegal;
    @(posedge clk);
    #1;
    valid = 1'b0; op = 2'b00; srcz = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    logic ill;
    acc(a, 2'b00, 32'h0, 1'b1, v, ill);
  endtask

  task automatic take_trap(input logic [31:0] pc, input logic irq, input logic [3:0] code);
    @(negedge clk);
    trap = 1'b1; trap_pc = pc; trap_irq = irq; trap_cause = code;
    @(posedge clk);
    #1 trap = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk);
    mret = 1'b1;
    @(posedge clk);
    #1 mret = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic        ill;
    logic [11:0] addrs [5];
    addrs = '{12'h300, 12'h305, 12'h340, 12'h341, 12'h342};

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 priv", {30'd0, priv}, 32'h3);
    chk("R1 ret_pc", ret_pc, 32'h0);
    foreach (addrs[i]) begin
      rd(addrs[i], v);
      chk("R1 reg zero", v, 32'h0);
    end

    // R2/R4 swap on scratch
    acc(12'h340, 2'b01, 32'hDEADBEEF, 1'b0, v, ill);
    chk("R2 swap old", v, 32'h0);
    acc(12'h340, 2'b01, 32'h12345678, 1'b0, v, ill);
    chk("R4 scratch full width", v, 32'hDEADBEEF);
    chk("R11 no flag on legal", {31'd0, ill}, 32'h0);
    rd(12'h340, v);
    chk("R2 swap new", v, 32'h12345678);

    // R3 set/clear and zero source
    acc(12'h340, 2'b10, 32'hF0000001, 1'b0, v, ill);
    chk("R3 set old", v, 32'h12345678);
    rd(12'h340, v);
    chk("R3 set result", v, 32'hF2345679);
    acc(12'h340, 2'b11, 32'h00FF00FF, 1'b0, v, ill);
    rd(12'h340, v);
    chk("R3 clear result", v, 32'hF2005600);
    acc(12'h340, 2'b10, 32'hFFFFFFFF, 1'b1, v, ill);
    chk("R3 set x0 old", v, 32'hF2005600);
    acc(12'h340, 2'b11, 32'hFFFFFFFF, 1'b1, v, ill);
    rd(12'h340, v);
    chk("R3 x0 no write", v, 32'hF2005600);

    // R5 exception PC alignment by software
    acc(12'h341, 2'b01, 32'hFFFFFFFF, 1'b0, v, ill);
    rd(12'h341, v);
    chk("R5 epc sw aligned", v, 32'hFFFFFFFC);
    chk("R9 ret_pc shows epc", ret_pc, 32'hFFFFFFFC);

    // R12 status masking
    acc(12'h300, 2'b01, 32'hFFFFFFFF, 1'b0, v, ill);
    rd(12'h300, v);
    chk("R12 status field only", v, 32'h00001800);

    // R6 cause sw write masking
    acc(12'h342, 2'b01, 32'hFFFFFFFF, 1'b0, v, ill);
    rd(12'h342, v);
    chk("R6 cause sw mask", v, 32'h8000000F);

    // R11 illegal address
    acc(12'h344, 2'b01, 32'h0BADF00D, 1'b0, v, ill);
    chk("R11 flag", {31'd0, ill}, 32'h1);
    chk("R11 reads zero", v, 32'h0);
    rd(12'h340, v);
    chk("R11 scratch untouched", v, 32'hF2005600);
    rd(12'h300, v);
    chk("R11 status untouched", v, 32'h00001800);

    // R9 drop to user: clear field, return
    acc(12'h300, 2'b01, 32'h0, 1'b0, v, ill);
    do_ret();
    #1 chk("R9 priv from field", {30'd0, priv}, 32'h0);
    rd(12'h300, v);
    chk("R9 field kept", v, 32'h0);

    // R6 trap capture from user mode
    take_trap(32'h00001236, 1'b1, 4'd7);
    #1 chk("R6 priv raised", {30'd0, priv}, 32'h3);
    chk("R6 ret_pc", ret_pc, 32'h00001234);
    rd(12'h341, v);
    chk("R5 epc trap aligned", v, 32'h00001234);
    rd(12'h342, v);
    chk("R6 cause irq", v, 32'h80000007);
    rd(12'h300, v);
    chk("R6 prev priv saved", v, 32'h0);
    do_ret();
    #1 chk("R9 back to user", {30'd0, priv}, 32'h0);

    // R6 synchronous cause, saved priv from user then machine
    take_trap(32'h00002000, 1'b0, 4'd2);
    rd(12'h342, v);
    chk("R6 cause exc", v, 32'h00000002);
    take_trap(32'h00003000, 1'b0, 4'd11);
    rd(12'h300, v);
    chk("R6 prev priv machine", v, 32'h00001800);

    // R10 trap beats sw write in same cycle
    @(negedge clk);
    valid = 1'b1; addr = 12'h341; op = 2'b01; wdata = 32'hAAAA0000; srcz = 1'b0;
    trap = 1'b1; trap_pc = 32'h00004444; trap_irq = 1'b0; trap_cause = 4'd5;
    @(posedge clk);
    #1 valid = 1'b0; op = 2'b00; trap = 1'b0;
    rd(12'h341, v);
    chk("R10 epc trap wins", v, 32'h00004444);
    @(negedge clk);
    valid = 1'b1; addr = 12'h342; op = 2'b01; wdata = 32'h8000000C;
    trap = 1'b1; trap_pc = 32'h00005550; trap_irq = 1'b1; trap_cause = 4'd3;
    @(posedge clk);
    #1 valid = 1'b0; op = 2'b00; trap = 1'b0;
    rd(12'h342, v);
    chk("R10 cause trap wins", v, 32'h80000003);

    // R7/R8 sweep of mode, flag and code
    for (int m = 0; m < 4; m++) begin
      logic [31:0] base;
      base = (m[0]) ? 32'h80000100 : 32'h00010000;
      acc(12'h305, 2'b01, base | 32'(m), 1'b0, v, ill);
      rd(12'h305, v);
      chk("R7 tvec readback", v, base | 32'(m));
      for (int irq = 0; irq < 2; irq++) begin
        for (int c = 0; c < 16; c++) begin
          logic [31:0] exp;
          @(negedge clk);
          trap_irq = irq[0]; trap_cause = c[3:0];
          #1;
          exp = (m == 1 && irq == 1) ? base + 32'(c) * 4 : base;
          chk((m == 1) ? "R8 vectored target" : "R7 direct target", target, exp);
        end
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule